// File: doc/BRIEF.md
# Two-Level Page Translation Unit

This block turns 32-bit linear addresses into physical addresses. When paging is off, the address passes through unchanged. When paging is on, the linear address is cut into a directory index, a table index and a byte offset. The walk starts at a directory base register and reads one entry from the page directory. That entry names a page table, and one entry from that table names the 4 KB frame. The byte offset is then appended to the frame to form the physical address.

An eight-entry fully associative cache of recent translations sits in front of the walk. A hit answers one cycle after the request is accepted, with no memory traffic. A miss issues exactly two table reads, one after the other, over a valid/ready read port. If an entry at either level is marked absent, the unit reports a fault and caches nothing. Writing the directory base register empties the whole cache.

Top module: `page_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, `mem_rd_valid` is 0 and the directory base is 0, so the first walk reads its directory entry at address `lin[31:22]*4`.
- R2: An accepted request with `pg_en`=0 responds in the next cycle with `resp_phys` equal to `req_lin`, `resp_fault`=0, and no memory read.
- R3: A miss reads the directory entry at `{base[31:12], lin[31:22], 2'b00}`, then reads the table entry at `{dir_entry[31:12], lin[21:12], 2'b00}`. The response comes in the cycle after the second read handshake, with `resp_phys = {tbl_entry[31:12], lin[11:0]}`.
- R4: Bit 0 of each entry is the present bit. If it is clear at either level, the walk stops at once with `resp_fault`=1 and `resp_phys`=0, and no translation is cached, so a repeat of the same address walks again.
- R5: A request whose upper 20 address bits match a cached translation responds in the next cycle with the cached frame and the new offset, and makes no memory read.
- R6: The cache holds 8 translations and replaces them round-robin. After nine distinct pages are installed into an empty cache, pages two to nine hit and the first page misses.
- R7: A directory base write empties the cache. A request accepted in the same cycle as the write is treated as a miss and walks from the newly written base.
- R8: If the base is written while a walk is in progress, the walk finishes using the base it started with and returns its result, but does not install it in the cache.
- R9: `mem_rd_valid` stays high with a stable `mem_rd_addr` until `mem_rd_ready`. `req_ready` is low from the time a miss is accepted until its response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translate request |
| req_ready | output | 1 | Unit can accept a request |
| req_lin | input | 32 | Linear address to translate |
| pg_en | input | 1 | Paging enable, sampled with the request |
| cr3_we | input | 1 | Write strobe for the directory base register |
| cr3_wdata | input | 32 | New directory base (bits 31:12 are used) |
| mem_rd_valid | output | 1 | Table entry read request |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_ready | input | 1 | Read accepted; data valid in this cycle |
| mem_rd_data | input | 32 | Table entry returned |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_phys | output | 32 | Physical address, 0 on fault |
| resp_fault | output | 1 | Page fault: an entry was not present |

## Verification
The bench sweeps linear addresses across many directory and table indices under a table memory whose entries are a simple arithmetic function of their address. Absent entries fall at known index residues, so the sweep separates directory-level faults (one read) from table-level faults (two reads) from clean translations. Bypass addresses with paging off show that the pass-through path does not touch memory. Varied read-ready delays tie the response cycle to the handshake count rather than to a fixed latency. Fill, hit, eviction and flush sequences tell round-robin replacement apart from other choices, and tell a mid-walk base write from a write that lands in the same cycle as a request.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int LIN_W  = 32;
    localparam int DIR_W  = 10;
    localparam int TBL_W  = 10;
    localparam int OFF_W  = 12;
    localparam int ENT_SH = 2;
    localparam int VPN_W  = DIR_W + TBL_W;
    localparam int PFN_W  = LIN_W - OFF_W;
    localparam int PRESENT_BIT = 0;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_DIR  = 2'd1,
        W_TBL  = 2'd2
    } wstate_e;
endpackage

// File: rtl/xlt_tcache.sv
module xlt_tcache
    import xlt_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  vpn_t lk_vpn,
    output logic lk_hit,
    output pfn_t lk_pfn,
    input  logic ins_en,
    input  vpn_t ins_vpn,
    input  pfn_t ins_pfn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]       vld;
        vpn_t [ENTRIES-1:0]       tag;
        pfn_t [ENTRIES-1:0]       pfn;
        logic [IDX_W-1:0]         ptr;
    } tc_state_t;

    tc_state_t q, d;
    logic [ENTRIES-1:0] match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = q.vld[i] && (q.tag[i] == lk_vpn);
    end

    always_comb begin
        lk_hit = |match;
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_pfn = lk_pfn | q.pfn[i];
        end
    end

    always_comb begin
        d = q;
        if (flush) begin
            d.vld = '0;
            d.ptr = '0;
        end else if (ins_en) begin
            d.vld[q.ptr] = 1'b1;
            d.tag[q.ptr] = ins_vpn;
            d.pfn[q.ptr] = ins_pfn;
            d.ptr        = (q.ptr == LAST) ? '0 : q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/xlt_walker.sv
module xlt_walker
    import xlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LIN_W-1:0]  req_lin,
    input  logic              pg_en,
    input  logic              hit,
    input  pfn_t              hit_pfn,
    input  pfn_t              base_pfn,
    input  logic              base_we,
    output logic              mem_rd_valid,
    output logic [LIN_W-1:0]  mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic [LIN_W-1:0]  mem_rd_data,
    output logic              ins_en,
    output vpn_t              ins_vpn,
    output pfn_t              ins_pfn,
    output logic              resp_valid,
    output logic [LIN_W-1:0]  resp_phys,
    output logic              resp_fault
);
    typedef struct packed {
        wstate_e          st;
        logic [LIN_W-1:0] lin;
        pfn_t             base;
        logic             stale;
        logic             rsp_vld;
        logic             rsp_flt;
        logic [LIN_W-1:0] rsp_pa;
    } wk_state_t;

    wk_state_t q, d;

    logic [DIR_W-1:0] dir_idx;
    logic [TBL_W-1:0] tbl_idx;
    logic             ent_present;
    pfn_t             ent_pfn;

    assign dir_idx     = q.lin[LIN_W-1 -: DIR_W];
    assign tbl_idx     = q.lin[OFF_W +: TBL_W];
    assign ent_present = mem_rd_data[PRESENT_BIT];
    assign ent_pfn     = mem_rd_data[LIN_W-1 -: PFN_W];

    always_comb begin
        d         = q;
        d.rsp_vld = 1'b0;
        d.rsp_flt = 1'b0;
        ins_en    = 1'b0;
        ins_vpn   = q.lin[LIN_W-1 -: VPN_W];
        ins_pfn   = ent_pfn;
        mem_rd_valid = (q.st != W_IDLE);
        mem_rd_addr  = (q.st == W_TBL) ? {q.base, tbl_idx, {ENT_SH{1'b0}}}
                                       : {q.base, dir_idx, {ENT_SH{1'b0}}};
        case (q.st)
            W_IDLE: begin
                if (req_valid) begin
                    if (!pg_en) begin
                        d.rsp_vld = 1'b1;
                        d.rsp_pa  = req_lin;
                    end else if (hit) begin
                        d.rsp_vld = 1'b1;
                        d.rsp_pa  = {hit_pfn, req_lin[OFF_W-1:0]};
                    end else begin
                        d.st    = W_DIR;
                        d.lin   = req_lin;
                        d.base  = base_pfn;
                        d.stale = 1'b0;
                    end
                end
            end
            W_DIR: begin
                if (base_we) d.stale = 1'b1;
                if (mem_rd_ready) begin
                    if (!ent_present) begin
                        d.st      = W_IDLE;
                        d.rsp_vld = 1'b1;
                        d.rsp_flt = 1'b1;
                        d.rsp_pa  = '0;
                    end else begin
                        d.st   = W_TBL;
                        d.base = ent_pfn;
                    end
                end
            end
            W_TBL: begin
                if (base_we) d.stale = 1'b1;
                if (mem_rd_ready) begin
                    d.st      = W_IDLE;
                    d.rsp_vld = 1'b1;
                    if (!ent_present) begin
                        d.rsp_flt = 1'b1;
                        d.rsp_pa  = '0;
                    end else begin
                        d.rsp_pa = {ent_pfn, q.lin[OFF_W-1:0]};
                        ins_en   = !(q.stale || base_we);
                    end
                end
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready  = (q.st == W_IDLE);
    assign resp_valid = q.rsp_vld;
    assign resp_fault = q.rsp_flt;
    assign resp_phys  = q.rsp_pa;
endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import xlt_pkg::*;
#(
    parameter int TC_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_lin,
    input  logic        pg_en,
    input  logic        cr3_we,
    input  logic [31:0] cr3_wdata,
    output logic        mem_rd_valid,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_ready,
    input  logic [31:0] mem_rd_data,
    output logic        resp_valid,
    output logic [31:0] resp_phys,
    output logic        resp_fault
);
    pfn_t base_q, base_d, base_eff;
    logic tc_hit, hit_ok;
    pfn_t tc_pfn;
    logic ins_en;
    vpn_t ins_vpn;
    pfn_t ins_pfn;

    always_comb begin
        base_d   = cr3_we ? cr3_wdata[LIN_W-1 -: PFN_W] : base_q;
        base_eff = base_d;
        hit_ok   = tc_hit && !cr3_we;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    xlt_tcache #(.ENTRIES(TC_ENTRIES)) tc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (cr3_we),
        .lk_vpn  (req_lin[LIN_W-1 -: VPN_W]),
        .lk_hit  (tc_hit),
        .lk_pfn  (tc_pfn),
        .ins_en  (ins_en),
        .ins_vpn (ins_vpn),
        .ins_pfn (ins_pfn)
    );

    xlt_walker wk_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_lin      (req_lin),
        .pg_en        (pg_en),
        .hit          (hit_ok),
        .hit_pfn      (tc_pfn),
        .base_pfn     (base_eff),
        .base_we      (cr3_we),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_data  (mem_rd_data),
        .ins_en       (ins_en),
        .ins_vpn      (ins_vpn),
        .ins_pfn      (ins_pfn),
        .resp_valid   (resp_valid),
        .resp_phys    (resp_phys),
        .resp_fault   (resp_fault)
    );
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_lin,
    input logic        pg_en,
    input logic        mem_rd_valid,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_ready,
    input logic        resp_valid,
    input logic [31:0] resp_phys,
    input logic        resp_fault
);
    a_r9_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    a_r9_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !pg_en |=>
            resp_valid && !resp_fault && resp_phys == $past(req_lin));

    a_r4_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> resp_valid && resp_phys == 32'h0);

    a_r3_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && req_ready) || $past(mem_rd_valid && mem_rd_ready));

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> req_ready && !mem_rd_valid && !resp_valid);
endmodule

bind page_xlate xlt_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_lin      (req_lin),
    .pg_en        (pg_en),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ready (mem_rd_ready),
    .resp_valid   (resp_valid),
    .resp_phys    (resp_phys),
    .resp_fault   (resp_fault)
);

// File: tb/page_xlate_tb_top.sv
module page_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        pg_en = 1'b0;
    logic        cr3_we = 1'b0;
    logic [31:0] cr3_wdata = '0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_data;
    logic        resp_valid;
    logic [31:0] resp_phys;
    logic        resp_fault;

    int n_chk = 0;
    int n_err = 0;
    int rd_cnt = 0;
    int mem_dly = 0;
    int wait_cnt = 0;
    logic [31:0] last_addr = '0;
    logic [31:0] prev_addr = '0;

    always #4 clk = ~clk;

    page_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin), .pg_en(pg_en),
        .cr3_we(cr3_we), .cr3_wdata(cr3_wdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
        .resp_valid(resp_valid), .resp_phys(resp_phys), .resp_fault(resp_fault)
    );

    // Table memory: region 1 holds directories, region 2 holds page tables.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [9:0] i;
        i = a[11:2];
        if (a[31:28] == 4'h1)
            return {4'h2, i, a[17:12], 11'h0, (i % 7 != 6)};
        else if (a[31:28] == 4'h2)
            return {4'h8, a[23:18] ^ a[17:12], i, 11'h0, (i % 5 != 4)};
        return 32'h0;
    endfunction

    assign mem_rd_data = mem_word(mem_rd_addr);

    always @(negedge clk) begin
        if (mem_rd_valid) begin
            if (wait_cnt >= mem_dly) begin mem_rd_ready = 1'b1; wait_cnt = 0; end
            else begin mem_rd_ready = 1'b0; wait_cnt++; end
        end else begin
            mem_rd_ready = 1'b0;
            wait_cnt = 0;
        end
    end

    always @(posedge clk) begin
        if (mem_rd_valid && mem_rd_ready) begin
            rd_cnt    <= rd_cnt + 1;
            prev_addr <= last_addr;
            last_addr <= mem_rd_addr;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Drive one request and check it against the arithmetic model.
    task automatic run(input logic [31:0] lin, input bit pg, input int dly, input bit exp_hit,
                       input bit mid_w, input bit same_w, input logic [31:0] new_base,
                       input logic [31:0] base_e, input string rq);
        int cyc, start, rds, exp_rds, exp_cyc;
        bit busy_bad, dflt, tflt, eflt;
        logic [9:0] dd, tt;
        logic [31:0] epa;
        busy_bad = 1'b0;
        @(negedge clk);
        mem_dly = dly;
        req_valid = 1'b1; req_lin = lin; pg_en = pg;
        start = rd_cnt;
        if (same_w) begin cr3_we = 1'b1; cr3_wdata = new_base; end
        @(negedge clk);
        req_valid = 1'b0; cr3_we = 1'b0;
        cyc = 1;
        if (mid_w) begin cr3_we = 1'b1; cr3_wdata = new_base; end
        while (!resp_valid && cyc < 300) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk);
            cr3_we = 1'b0;
            cyc++;
        end
        cr3_we = 1'b0;
        rds = rd_cnt - start;
        dd = lin[31:22]; tt = lin[21:12];
        dflt = (base_e[31:28] != 4'h1) || (dd % 7 == 6);
        tflt = (tt % 5 == 4);
        if (!pg) begin
            eflt = 0; epa = lin; exp_rds = 0; exp_cyc = 1;
        end else if (exp_hit) begin
            eflt = 0; epa = {4'h8, dd[5:0] ^ base_e[17:12], tt, lin[11:0]};
            exp_rds = 0; exp_cyc = 1;
        end else begin
            eflt = dflt || tflt;
            epa = eflt ? 32'h0 : {4'h8, dd[5:0] ^ base_e[17:12], tt, lin[11:0]};
            exp_rds = dflt ? 1 : 2;
            exp_cyc = exp_rds * (dly + 1) + 1;
        end
        chk(resp_valid === 1'b1, {rq, " response strobe"}, 32'(resp_valid), 32'd1);
        chk(resp_fault === eflt, {rq, " fault flag"}, 32'(resp_fault), 32'(eflt));
        chk(resp_phys === epa, {rq, " physical address"}, resp_phys, epa);
        chk(rds == exp_rds, {rq, " memory reads"}, 32'(rds), 32'(exp_rds));
        chk(cyc == exp_cyc, {rq, " response cycle"}, 32'(cyc), 32'(exp_cyc));
        if (exp_rds == 2) begin
            chk(prev_addr === {base_e[31:12], dd, 2'b00}, {rq, " directory entry address"},
                prev_addr, {base_e[31:12], dd, 2'b00});
            chk(last_addr === {4'h2, dd, base_e[17:12], tt, 2'b00}, {rq, " table entry address"},
                last_addr, {4'h2, dd, base_e[17:12], tt, 2'b00});
        end else if (exp_rds == 1) begin
            chk(last_addr === {base_e[31:12], dd, 2'b00}, {rq, " directory entry address"},
                last_addr, {base_e[31:12], dd, 2'b00});
        end
        if (exp_rds > 0) chk(!busy_bad, "R9 req_ready low during walk", 32'(busy_bad), 32'd0);
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        cr3_we = 1'b1; cr3_wdata = b;
        @(negedge clk);
        cr3_we = 1'b0;
    endtask

    function automatic logic [31:0] good_page(input int k, input logic [11:0] off);
        int d;
        d = (k < 6) ? k : k + 1;
        return {10'(d), 10'd0, off};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] b0, b1, b2;
        b0 = 32'h1003_5000;
        b1 = 32'h1001_2000;
        b2 = 32'h1002_7000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(req_ready === 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
        chk(resp_valid === 1'b0, "R1 resp_valid after reset", 32'(resp_valid), 32'd0);
        chk(mem_rd_valid === 1'b0, "R1 mem_rd_valid after reset", 32'(mem_rd_valid), 32'd0);
        // R1: zero base, read lands at index*4 and yields an absent entry
        run(32'h00C0_0123, 1'b1, 0, 0, 0, 0, '0, 32'h0, "R1 zero base walk");

        set_base(b0);
        // R2: bypass sweep
        for (int i = 0; i < 16; i++)
            run(32'h1357_9BDF * (i + 1) + i, 1'b0, 0, 0, 0, 0, '0, b0, "R2 bypass");

        // R3/R4: miss sweep over directory and table indices, varied ready delay
        for (int d = 0; d < 14; d++) begin
            for (int t = 0; t < 10; t += 3) begin
                set_base((d % 2 == 0) ? b0 : b1);
                run({10'(d), 10'(t), 12'(d * 97 + t)}, 1'b1, (d + t) % 3, 0, 0, 0, '0,
                    (d % 2 == 0) ? b0 : b1, "R3 miss walk");
            end
        end

        // R4: table-level and directory-level faults are not cached
        set_base(b0);
        run({10'd2, 10'd9, 12'h010}, 1'b1, 1, 0, 0, 0, '0, b0, "R4 table fault");
        run({10'd2, 10'd9, 12'h020}, 1'b1, 0, 0, 0, 0, '0, b0, "R4 table fault repeat");
        run({10'd6, 10'd1, 12'h030}, 1'b1, 0, 0, 0, 0, '0, b0, "R4 directory fault");
        run({10'd6, 10'd1, 12'h040}, 1'b1, 2, 0, 0, 0, '0, b0, "R4 directory fault repeat");

        // R5: repeat of a translated page hits with a new offset
        run({10'd3, 10'd2, 12'h111}, 1'b1, 1, 0, 0, 0, '0, b0, "R5 fill");
        for (int i = 0; i < 4; i++)
            run({10'd3, 10'd2, 12'(i * 1000 + 5)}, 1'b1, 2, 1, 0, 0, '0, b0, "R5 hit");

        // R6: nine installs into an empty cache, round-robin eviction
        set_base(b2);
        for (int k = 0; k < 9; k++)
            run(good_page(k, 12'(k)), 1'b1, 0, 0, 0, 0, '0, b2, "R6 install");
        for (int k = 1; k < 9; k++)
            run(good_page(k, 12'h7F0), 1'b1, 0, 1, 0, 0, '0, b2, "R6 resident hit");
        run(good_page(0, 12'h123), 1'b1, 0, 0, 0, 0, '0, b2, "R6 evicted page misses");

        // R7: base write flushes; same-cycle request walks from new base
        set_base(b2);
        run(good_page(3, 12'h0AA), 1'b1, 0, 0, 0, 0, '0, b2, "R7 after flush");
        run(good_page(3, 12'h0AB), 1'b1, 0, 1, 0, 0, '0, b2, "R7 refill hit");
        run(good_page(3, 12'h0AC), 1'b1, 1, 0, 0, 1, b1, b1, "R7 same-cycle write");

        // R8: base write during a walk: old base result, nothing cached
        set_base(b0);
        run(good_page(4, 12'h321), 1'b1, 3, 0, 1, 0, b1, b0, "R8 mid-walk write");
        run(good_page(4, 12'h322), 1'b1, 0, 0, 0, 0, '0, b1, "R8 no install after stale walk");

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule